// File: doc/BRIEF.md
# Calibration Register Read Responder (one data lane)

This block stands in for the memory side of a DDR3 link while the controller runs read calibration. A mode-register write to MR3 switches the calibration-register read function on or off and picks one of four data locations. While the function is on, each read command returns the selected location one bit per beat on a single data lane. A read is either a full eight-beat burst or a four-beat chop, and the column start address sets the order in which register bits appear.

The responder also polices command spacing. A read must wait a mode-register settle time after the write that enabled the function. Two mode-register writes must be spaced by a minimum gap. A mode-register write that would reload or disable the function must wait a recovery interval after the last beat of a burst. A command that breaks one of these rules is dropped and sets a sticky error flag. The flag stays set until reset. Double-rate edge placement, the strobe, the array and ordinary reads and writes are not modelled.

Top module: `mprResponder`

## Requirements
- R1: After reset, dqValid, dq and errFlag are all 0 and the function is disabled.
- R2: A command with cmdValid=1 and cmdRead=0 is an MR3 write. cmdAddr[2]=1 enables the function and cmdAddr[2]=0 disables it. cmdAddr[1:0] selects the location. Location 0 holds the PATTERN parameter, default 8'hAA, so the beats run 0,1,0,1,... in burst order. Locations 1, 2 and 3 read as all zeros.
- R3: The beat that carries burst-order position k drives bit k of the selected location word, with bit 0 the LSB.
- R4: A read with cmdBc4=0 returns exactly 8 beats. With cmdAddr[2]=0 the burst order is 0..7, and with cmdAddr[2]=1 it is 4,5,6,7,0,1,2,3. cmdAddr[1:0] has no effect on reads.
- R5: A read with cmdBc4=1 returns exactly 4 beats. The burst order is 0,1,2,3 when cmdAddr[2]=0 and 4,5,6,7 when cmdAddr[2]=1.
- R6: For a read accepted at clock edge E, dqValid is high in RD_LAT+n-1 down to RD_LAT: the n contiguous cycles that follow edges E+RD_LAT through E+RD_LAT+n-1.
- R7: dq is 0 whenever dqValid is 0.
- R8: A read issued while the function is disabled produces no beats and sets errFlag.
- R9: A read issued earlier than max(TMOD,TMRD) edges after the last accepted MR3 write is ignored and sets errFlag. A read issued at exactly that distance is accepted.
- R10: An MR3 write issued earlier than TMRD edges after the previous accepted one is ignored, leaving the configuration unchanged, and sets errFlag.
- R11: An MR3 write issued while a read is pending or bursting, or earlier than TMPRR edges after the edge that ends the last beat, is ignored and sets errFlag. An MR3 write issued exactly at that bound is accepted.
- R12: A read issued while another read is pending or bursting is ignored and sets errFlag. The burst already in flight completes unchanged.
- R13: Once set, errFlag stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdValid | input | 1 | A command is present this cycle |
| cmdRead | input | 1 | 1 = read command, 0 = MR3 write |
| cmdBc4 | input | 1 | For reads: 1 = four-beat chop, 0 = eight-beat burst |
| cmdAddr | input | 3 | MR3 write: [2] enable, [1:0] location; read: column start |
| dq | output | 1 | Serial data beat |
| dqValid | output | 1 | High for each beat of a burst |
| errFlag | output | 1 | Sticky timing or protocol violation |

## Verification
The assertions check the following on every cycle:
- every burst is 4 or 8 beats long;
- dq is quiet outside beats;
- the error flag never clears;
- a read while disabled sets the flag;
- an MR3 write or a second read that lands during a burst sets the flag.

The bench scenarios cover what the assertions cannot see. These are the bit ordering for each start address and chop mode, the reserved locations reading as zero, and the exact read latency. They also cover the one-edge boundaries of the settle, spacing and recovery limits. A second instance with an asymmetric pattern shows the ordering, because the default alternating pattern looks the same under every start address.

// File: rtl/mprPkg.sv
package mprPkg;
  localparam int REG_W  = 8;
  localparam int LOC_W  = 2;
  localparam int ADDR_W = 3;
  localparam int BEAT_W = $clog2(REG_W);

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BURST
  } seqState_t;

  typedef struct packed {
    logic cfgWrite;   // accept MR3 write: capture enable and location
    logic burstLoad;  // accept read: capture start half, reset beat index
    logic beatStep;   // one beat is driven this cycle
  } ctrlStrobe_t;
endpackage

// File: rtl/mprDatapath.sv
module mprDatapath
  import mprPkg::*;
#(
  parameter logic [REG_W-1:0] PATTERN = 8'hAA
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic              beatValid,
  output logic              mprOn,
  output logic              dq
);
  localparam int NUM_LOC = 1 << LOC_W;

  logic [LOC_W-1:0]  locSel;
  logic              startHigh;
  logic [BEAT_W-1:0] beatIdx;
  logic [BEAT_W-1:0] orderPos;
  logic [REG_W-1:0]  locTable [NUM_LOC];

  // location 0 carries the calibration word, the rest read as zero
  for (genvar g = 0; g < NUM_LOC; g++) begin : gLoc
    if (g == 0) begin : gPat
      assign locTable[g] = PATTERN;
    end else begin : gZero
      assign locTable[g] = '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mprOn     <= 1'b0;
      locSel    <= '0;
      startHigh <= 1'b0;
      beatIdx   <= '0;
    end else begin
      if (strobe.cfgWrite) begin
        mprOn  <= cmdAddr[2];
        locSel <= cmdAddr[1:0];
      end
      if (strobe.burstLoad) begin
        startHigh <= cmdAddr[2];
        beatIdx   <= '0;
      end else if (strobe.beatStep) begin
        beatIdx <= beatIdx + 1'b1;
      end
    end
  end

  // upper start flips the half; low column bits never enter the order
  assign orderPos = {startHigh ^ beatIdx[BEAT_W-1], beatIdx[BEAT_W-2:0]};
  assign dq       = beatValid & locTable[locSel][orderPos];
endmodule

// File: rtl/mprCtrl.sv
module mprCtrl
  import mprPkg::*;
#(
  parameter int TMOD   = 12,
  parameter int TMRD   = 4,
  parameter int TMPRR  = 2,
  parameter int RD_LAT = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdValid,
  input  logic        cmdRead,
  input  logic        cmdBc4,
  input  logic        mprOn,
  output ctrlStrobe_t strobe,
  output logic        beatValid,
  output logic        errFlag
);
  localparam int T_RD  = (TMOD > TMRD) ? TMOD : TMRD;
  localparam int T_M1  = (T_RD > TMPRR) ? T_RD : TMPRR;
  localparam int T_MAX = (T_M1 > RD_LAT) ? T_M1 : RD_LAT;
  localparam int CW    = $clog2(T_MAX + 1);
  localparam logic [BEAT_W-1:0] LAST_BL8 = BEAT_W'(REG_W - 1);
  localparam logic [BEAT_W-1:0] LAST_BC4 = BEAT_W'(REG_W / 2 - 1);

  seqState_t         state;
  logic [CW-1:0]     latCnt;
  logic [CW-1:0]     rdGap;
  logic [CW-1:0]     mrsGap;
  logic [CW-1:0]     recov;
  logic [BEAT_W-1:0] beatsLeft;
  logic isMrs, isRd, mrsOk, rdOk, violation;

  always_comb begin
    isMrs     = cmdValid && !cmdRead;
    isRd      = cmdValid && cmdRead;
    mrsOk     = (state == ST_IDLE) && (mrsGap == '0) && (recov == '0);
    rdOk      = (state == ST_IDLE) && mprOn && (rdGap == '0);
    strobe.cfgWrite  = isMrs && mrsOk;
    strobe.burstLoad = isRd && rdOk;
    strobe.beatStep  = (state == ST_BURST);
    violation = (isMrs && !mrsOk) || (isRd && !rdOk);
  end

  assign beatValid = (state == ST_BURST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      latCnt    <= '0;
      rdGap     <= '0;
      mrsGap    <= '0;
      recov     <= '0;
      beatsLeft <= '0;
      errFlag   <= 1'b0;
    end else begin
      errFlag <= errFlag | violation;
      if (rdGap  != '0) rdGap  <= rdGap  - 1'b1;
      if (mrsGap != '0) mrsGap <= mrsGap - 1'b1;
      if (recov  != '0) recov  <= recov  - 1'b1;
      if (strobe.cfgWrite) begin
        rdGap  <= CW'(T_RD - 1);
        mrsGap <= CW'(TMRD - 1);
      end
      case (state)
        ST_IDLE: begin
          if (strobe.burstLoad) begin
            state     <= ST_WAIT;
            latCnt    <= CW'(RD_LAT - 1);
            beatsLeft <= cmdBc4 ? LAST_BC4 : LAST_BL8;
          end
        end
        ST_WAIT: begin
          if (latCnt == '0) state <= ST_BURST;
          else latCnt <= latCnt - 1'b1;
        end
        ST_BURST: begin
          if (beatsLeft == '0) begin
            state <= ST_IDLE;
            recov <= CW'(TMPRR - 1);
          end else begin
            beatsLeft <= beatsLeft - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mprResponder.sv
module mprResponder
  import mprPkg::*;
#(
  parameter logic [REG_W-1:0] PATTERN = 8'hAA,
  parameter int TMOD   = 12,
  parameter int TMRD   = 4,
  parameter int TMPRR  = 2,
  parameter int RD_LAT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic              cmdRead,
  input  logic              cmdBc4,
  input  logic [ADDR_W-1:0] cmdAddr,
  output logic              dq,
  output logic              dqValid,
  output logic              errFlag
);
  ctrlStrobe_t strobe;
  logic        mprOn;

  mprCtrl #(.TMOD(TMOD), .TMRD(TMRD), .TMPRR(TMPRR), .RD_LAT(RD_LAT)) i_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead),
    .cmdBc4(cmdBc4), .mprOn(mprOn), .strobe(strobe),
    .beatValid(dqValid), .errFlag(errFlag)
  );

  mprDatapath #(.PATTERN(PATTERN)) i_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdAddr(cmdAddr),
    .beatValid(dqValid), .mprOn(mprOn), .dq(dq)
  );
endmodule

// File: rtl/mprResponderChk.sv
module mprResponderChk (
  input logic clk,
  input logic rstN,
  input logic cmdValid,
  input logic cmdRead,
  input logic mprOn,
  input logic dq,
  input logic dqValid,
  input logic errFlag
);
  logic [3:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) runLen <= '0;
    else if (dqValid) runLen <= runLen + 1'b1;
    else runLen <= '0;
  end

  // R4 and R5: each burst ends after exactly 4 or 8 beats
  assert_burst_len_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dqValid) |-> (runLen == 4'd4 || runLen == 4'd8));
  assert_run_cap_R4: assert property (@(posedge clk) disable iff (!rstN)
    dqValid |-> runLen < 4'd8);
  assert_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !dqValid |-> !dq);
  assert_sticky_R13: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);
  assert_read_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdRead && !mprOn) |=> errFlag);
  assert_mrs_busy_R11: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdRead && dqValid) |=> errFlag);
  assert_rd_busy_R12: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdRead && dqValid) |=> errFlag);
endmodule

bind mprResponder mprResponderChk i_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead),
  .mprOn(mprOn), .dq(dq), .dqValid(dqValid), .errFlag(errFlag)
);

// File: tb/test_mprResponder.sv
module test_mprResponder;
  localparam int CLK_PERIOD = 10;
  localparam int TMOD   = 6;
  localparam int TMRD   = 3;
  localparam int TMPRR  = 4;
  localparam int RD_LAT = 3;

  typedef struct packed {
    logic [1:0] loc;
    logic       bc4;
    logic [2:0] col;
    logic [7:0] expDef;
    logic [7:0] expAlt;
    logic [3:0] n;
  } vec_t;

  // beat 0 of the stream sits in bit 0; alt instance holds 8'hCA
  localparam vec_t VEC [9] = '{
    '{2'd0, 1'b0, 3'd0, 8'hAA, 8'hCA, 4'd8},
    '{2'd0, 1'b0, 3'd4, 8'hAA, 8'hAC, 4'd8},
    '{2'd0, 1'b0, 3'd5, 8'hAA, 8'hAC, 4'd8},
    '{2'd0, 1'b1, 3'd0, 8'h0A, 8'h0A, 4'd4},
    '{2'd0, 1'b1, 3'd4, 8'h0A, 8'h0C, 4'd4},
    '{2'd0, 1'b1, 3'd7, 8'h0A, 8'h0C, 4'd4},
    '{2'd2, 1'b0, 3'd0, 8'h00, 8'h00, 4'd8},
    '{2'd3, 1'b1, 3'd4, 8'h00, 8'h00, 4'd4},
    '{2'd1, 1'b0, 3'd4, 8'h00, 8'h00, 4'd8}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0, cmdRead = 1'b0, cmdBc4 = 1'b0;
  logic [2:0] cmdAddr = '0;
  logic dqD, dqValidD, errD, dqA, dqValidA, errA;
  int nTests = 0, nFail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mprResponder #(.TMOD(TMOD), .TMRD(TMRD), .TMPRR(TMPRR), .RD_LAT(RD_LAT)) i_mprResponder (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead), .cmdBc4(cmdBc4),
    .cmdAddr(cmdAddr), .dq(dqD), .dqValid(dqValidD), .errFlag(errD));

  mprResponder #(.PATTERN(8'hCA), .TMOD(TMOD), .TMRD(TMRD), .TMPRR(TMPRR), .RD_LAT(RD_LAT)) i_mprResponderAlt (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdRead(cmdRead), .cmdBc4(cmdBc4),
    .cmdAddr(cmdAddr), .dq(dqA), .dqValid(dqValidA), .errFlag(errA));

  task automatic chk(input string req, input string what, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic rd, input logic bc4, input logic [2:0] addr);
    cmdValid = 1'b1; cmdRead = rd; cmdBc4 = bc4; cmdAddr = addr;
    @(posedge clk); @(negedge clk);
    cmdValid = 1'b0; cmdRead = 1'b0; cmdBc4 = 1'b0; cmdAddr = '0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    idle(3);
    rstN = 1'b1;
    idle(1);
  endtask

  // samples at the negedge after edge E0+c; returns first valid index
  task automatic capture(input int c0, output logic [7:0] sDef, output logic [7:0] sAlt,
                         output int nDef, output int nAlt, output int firstC, output int noisy);
    sDef = '0; sAlt = '0; nDef = 0; nAlt = 0; firstC = -1; noisy = 0;
    for (int c = c0; c < c0 + RD_LAT + 12; c++) begin
      if (c != c0) begin @(posedge clk); @(negedge clk); end
      if (dqValidD) begin
        if (firstC < 0) firstC = c;
        if (nDef < 8) sDef[nDef] = dqD;
        nDef++;
      end else if (dqD) noisy++;
      if (dqValidA) begin
        if (nAlt < 8) sAlt[nAlt] = dqA;
        nAlt++;
      end else if (dqA) noisy++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nTests++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] sD, sA;
    int nD, nA, fc, nz;
    idle(2);
    // R1 reset state
    chk("R1", "dqValid", dqValidD, 0);
    chk("R1", "dq", dqD, 0);
    chk("R1", "errFlag", errD, 0);
    rstN = 1'b1;
    idle(1);

    // table walk: R2 R3 R4 R5 R6 R7 R9
    foreach (VEC[i]) begin
      issue(1'b0, 1'b0, {1'b1, VEC[i].loc});
      idle(TMOD - 1);
      issue(1'b1, VEC[i].bc4, VEC[i].col);
      capture(0, sD, sA, nD, nA, fc, nz);
      chk("R4/R5", "beat count", nD, VEC[i].n);
      chk("R2/R3", "default stream", sD, VEC[i].expDef);
      chk("R3/R4", "alt stream", sA, VEC[i].expAlt);
      chk("R6", "first beat cycle", fc, RD_LAT);
      chk("R7", "dq outside beats", nz, 0);
      chk("R9", "no error at bound", errD, 0);
    end

    // R8 read while disabled after reset
    doReset();
    chk("R1", "err after reset", errD, 0);
    issue(1'b1, 1'b0, 3'd0);
    capture(0, sD, sA, nD, nA, fc, nz);
    chk("R8", "beats while off", nD, 0);
    chk("R8", "errFlag", errD, 1);

    // R9 read one edge too early
    doReset();
    issue(1'b0, 1'b0, 3'b100);
    idle(TMOD - 2);
    issue(1'b1, 1'b0, 3'd0);
    chk("R9", "early read err", errD, 1);
    capture(0, sD, sA, nD, nA, fc, nz);
    chk("R9", "early read beats", nD, 0);

    // R10 second MR3 write too early is dropped
    doReset();
    issue(1'b0, 1'b0, 3'b100);
    idle(TMRD - 2);
    issue(1'b0, 1'b0, 3'b101);
    chk("R10", "early MRS err", errD, 1);
    idle(TMOD);
    issue(1'b1, 1'b0, 3'd0);
    capture(0, sD, sA, nD, nA, fc, nz);
    chk("R10", "config kept", sA, 8'hCA);
    // R10 at the bound it takes effect
    doReset();
    issue(1'b0, 1'b0, 3'b100);
    idle(TMRD - 1);
    issue(1'b0, 1'b0, 3'b101);
    chk("R10", "MRS at bound err", errD, 0);
    idle(TMOD - 1);
    issue(1'b1, 1'b0, 3'd0);
    capture(0, sD, sA, nD, nA, fc, nz);
    chk("R10", "new location zeros", sA, 8'h00);
    chk("R10", "new location beats", nA, 8);

    // R11 recovery after a chop burst: one edge early
    doReset();
    issue(1'b0, 1'b0, 3'b100);
    idle(TMOD - 1);
    issue(1'b1, 1'b1, 3'd0);
    idle(RD_LAT + 4 + TMPRR - 2);
    issue(1'b0, 1'b0, 3'b101);
    chk("R11", "early reload err", errD, 1);
    idle(TMOD);
    issue(1'b1, 1'b0, 3'd0);
    capture(0, sD, sA, nD, nA, fc, nz);
    chk("R11", "reload ignored", sA, 8'hCA);
    // R11 exactly at the bound
    doReset();
    issue(1'b0, 1'b0, 3'b100);
    idle(TMOD - 1);
    issue(1'b1, 1'b1, 3'd0);
    idle(RD_LAT + 4 + TMPRR - 1);
    issue(1'b0, 1'b0, 3'b110);
    chk("R11", "reload at bound err", errD, 0);
    idle(TMOD - 1);
    issue(1'b1, 1'b0, 3'd0);
    capture(0, sD, sA, nD, nA, fc, nz);
    chk("R11", "reloaded zeros", sA, 8'h00);
    // R11 MR3 write during a burst
    doReset();
    issue(1'b0, 1'b0, 3'b100);
    idle(TMOD - 1);
    issue(1'b1, 1'b0, 3'd0);
    idle(RD_LAT);
    issue(1'b0, 1'b0, 3'b000);
    chk("R11", "MRS in burst err", errD, 1);

    // R12 second read while one is pending
    doReset();
    issue(1'b0, 1'b0, 3'b100);
    idle(TMOD - 1);
    issue(1'b1, 1'b0, 3'd0);
    issue(1'b1, 1'b1, 3'd4);
    chk("R12", "overlap err", errD, 1);
    capture(1, sD, sA, nD, nA, fc, nz);
    chk("R12", "first burst beats", nA, 8);
    chk("R12", "first burst data", sA, 8'hCA);
    chk("R12", "first burst latency", fc, RD_LAT);

    // R8 disable via MR3, then read
    doReset();
    issue(1'b0, 1'b0, 3'b100);
    idle(TMOD - 1);
    issue(1'b0, 1'b0, 3'b000);
    chk("R8", "disable accepted", errD, 0);
    idle(TMOD);
    issue(1'b1, 1'b0, 3'd0);
    capture(0, sD, sA, nD, nA, fc, nz);
    chk("R8", "beats after disable", nD, 0);
    chk("R8", "err after disable read", errD, 1);

    // R13 flag persists through idle time and a legal command
    idle(20);
    issue(1'b0, 1'b0, 3'b100);
    idle(5);
    chk("R13", "sticky default", errD, 1);
    chk("R13", "sticky alt", errA, 1);

    finishRun();
  end
endmodule